// File: doc/BRIEF.md
# Misaligned Load Splitter

This unit connects a processor load port to a memory bus that is 32 bits wide and organised as 4-byte words. Each load request gives a byte address, an access size (byte, halfword or word), a strict flag and a sign-extend flag. The unit first decides whether the access is naturally aligned, meaning the address is a multiple of the access size. A byte is aligned at any address, a halfword only at even addresses, and a word only at multiples of four.

In non-strict operation, an access that fits inside one bus word costs one bus read. An access that runs past the end of its word is split into two aligned reads: the word holding the first byte, then the next word. The bytes from both reads are joined in little-endian lane order. In strict operation, any misaligned access ends with an alignment exception that reports the faulting address, and no bus read is made.

Only one load is handled at a time. The request side uses a valid/ready handshake. The response is a one-cycle done pulse with the data, or a one-cycle exception pulse with the address. The bus side has a single request/acknowledge read port whose latency can vary.

Top module: `load_split_unit`

## Requirements
- R1: An aligned word load (address bits [1:0] = 00, size code 2) makes exactly one bus read, at the request address, and returns that bus word unchanged.
- R2: A word load at offset 1, 2 or 3 in non-strict mode makes two bus reads. The first is at the address with its two low bits cleared, the second is 4 above that. The result holds the request's four bytes in address order, with the lowest-addressed byte in bits [7:0].
- R3: A halfword load (size code 1) at offset 0, 1 or 2 makes one bus read. At offset 3 it makes two reads, in the same order as R2. Result bits [15:0] hold the two bytes in address order.
- R4: A byte load (size code 0) at any address makes one bus read. Result bits [7:0] hold the byte from lane (address mod 4), where lane 0 is bus bits [7:0].
- R5: When reqStrict is 1 and the access is misaligned (odd halfword, or word not at a multiple of 4), the unit raises rspExc for one cycle with rspAddr equal to the request address, raises no rspDone, and makes no bus read. Aligned accesses in strict mode behave as in R1, R3 and R4.
- R6: With reqSigned at 0, the result bits above the loaded size are zero. With reqSigned at 1, they copy the top bit of the most significant loaded byte.
- R7: reqReady is 1 only when the unit is idle. It is 0 from the cycle after a request is accepted through the response cycle, and it is 1 again in the cycle after the response.
- R8: busReq stays high with a stable, word-aligned busAddr until busAck is seen. rspDone rises in the cycle after the final busAck and lasts exactly one cycle.
- R9: While rstN is low, and right after it is released, reqReady is 1 and busReq, rspDone and rspExc are 0. A reset during a bus read drops the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Unit can accept a request |
| reqAddr | input | AW | Byte address of the load |
| reqSize | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| reqStrict | input | 1 | Raise an exception on misalignment instead of splitting |
| reqSigned | input | 1 | Sign-extend the result |
| rspDone | output | 1 | One-cycle pulse, rspData valid |
| rspExc | output | 1 | One-cycle alignment exception pulse |
| rspData | output | DW | Loaded and extended data |
| rspAddr | output | AW | Address of the accepted request (faulting address on exception) |
| busReq | output | 1 | Bus read request, held until acknowledged |
| busAddr | output | AW | Word-aligned bus read address |
| busAck | input | 1 | Bus read acknowledge, one cycle, with data |
| busData | input | DW | Bus read data, valid with busAck |

## Verification
The bench aims at the lane boundary. It loads words at all three misaligned offsets and halfwords on both sides of offset 3. A design that splits on the wrong condition shows up as a wrong read count or wrong read addresses, and one that swaps the two words or shifts by the wrong lane count returns bytes out of order. Strict mode is tested with an odd halfword that would fit in one word. A design that checks for word crossing instead of alignment reads the bus rather than faulting. Signed byte and halfword loads whose top bit is set catch extension from the wrong byte. Bus latency changes from load to load, and one reset lands in the middle of a read, to catch a unit that drops its address early or does not clear a read that is already in flight.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} accSize_e;

  typedef enum logic [2:0] {ST_IDLE, ST_RD1, ST_RD2, ST_DONE, ST_EXC} lsuState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;       // request accepted this cycle
    logic capFirst;   // store first bus word
    logic capSecond;  // store second bus word
    logic useNext;    // drive address of the following word
  } lsuCtl_t;
endpackage

// File: rtl/lsu_dpath.sv
`timescale 1ns/1ps
module lsu_dpath
  import lsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  lsuCtl_t       ctl,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    reqSize,
  input  logic          reqSigned,
  input  logic [DW-1:0] busData,
  output logic          inMis,
  output logic          spanQ,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] rspData,
  output logic [AW-1:0] rspAddr
);
  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);
  localparam int SPW   = OFFW + 2;

  logic [SPW-1:0]  inBytes;
  logic [SPW-1:0]  inEnd;
  logic [OFFW-1:0] inOff;
  logic [OFFW-1:0] sizeMask;
  logic            inSpan;

  // classify the incoming request
  always_comb begin
    inOff    = reqAddr[OFFW-1:0];
    inBytes  = SPW'(1) << reqSize;
    sizeMask = OFFW'(inBytes - SPW'(1));
    inMis    = |(inOff & sizeMask);
    inEnd    = SPW'(inOff) + inBytes;
    inSpan   = inEnd > SPW'(LANES);
  end

  logic [AW-1:0] addrQ;
  accSize_e      sizeQ;
  logic          sgnQ;
  logic [DW-1:0] w0Q, w1Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      sizeQ <= SZ_BYTE;
      sgnQ  <= 1'b0;
      spanQ <= 1'b0;
      w0Q   <= '0;
      w1Q   <= '0;
    end else begin
      if (ctl.take) begin
        addrQ <= reqAddr;
        sizeQ <= accSize_e'(reqSize);
        sgnQ  <= reqSigned;
        spanQ <= inSpan;
      end
      if (ctl.capFirst)  w0Q <= busData;
      if (ctl.capSecond) w1Q <= busData;
    end
  end

  logic [AW-1:0] baseAddr;
  always_comb begin
    baseAddr = {addrQ[AW-1:OFFW], {OFFW{1'b0}}};
    busAddr  = ctl.useNext ? baseAddr + AW'(LANES) : baseAddr;
  end

  // lane merge: shift the word pair down by the byte offset
  logic [2*DW-1:0] pairShift;
  logic [DW-1:0]   raw;
  logic            signBit;
  always_comb begin
    pairShift = {w1Q, w0Q} >> {addrQ[OFFW-1:0], 3'b000};
    raw       = pairShift[DW-1:0];
    signBit   = 1'b0;
    rspData   = raw;
    case (sizeQ)
      SZ_BYTE: begin
        signBit = sgnQ & raw[7];
        rspData = {{(DW-8){signBit}}, raw[7:0]};
      end
      SZ_HALF: begin
        signBit = sgnQ & raw[15];
        rspData = {{(DW-16){signBit}}, raw[15:0]};
      end
      default: rspData = raw;
    endcase
  end

  assign rspAddr = addrQ;

  // a second word is only captured for an access that runs past its word
  assert_second_needs_span_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capSecond |-> spanQ);
endmodule

// File: rtl/lsu_ctrl.sv
`timescale 1ns/1ps
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqStrict,
  input  logic    inMis,
  input  logic    spanQ,
  input  logic    busAck,
  output logic    reqReady,
  output logic    busReq,
  output logic    rspDone,
  output logic    rspExc,
  output lsuCtl_t ctl
);
  lsuState_e state, stateNext;

  always_comb begin
    reqReady      = (state == ST_IDLE);
    busReq        = (state == ST_RD1) || (state == ST_RD2);
    rspDone       = (state == ST_DONE);
    rspExc        = (state == ST_EXC);
    ctl.take      = reqReady && reqValid;
    ctl.capFirst  = (state == ST_RD1) && busAck;
    ctl.capSecond = (state == ST_RD2) && busAck;
    ctl.useNext   = (state == ST_RD2);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (ctl.take) stateNext = (reqStrict && inMis) ? ST_EXC : ST_RD1;
      ST_RD1:  if (busAck)   stateNext = spanQ ? ST_RD2 : ST_DONE;
      ST_RD2:  if (busAck)   stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assert_busy_after_take_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

// File: rtl/load_split_unit.sv
`timescale 1ns/1ps
module load_split_unit
  import lsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    reqSize,
  input  logic          reqStrict,
  input  logic          reqSigned,
  output logic          rspDone,
  output logic          rspExc,
  output logic [DW-1:0] rspData,
  output logic [AW-1:0] rspAddr,
  output logic          busReq,
  output logic [AW-1:0] busAddr,
  input  logic          busAck,
  input  logic [DW-1:0] busData
);
  localparam int OFFW = $clog2(DW / 8);

  lsuCtl_t ctl;
  logic    inMis;
  logic    spanQ;

  lsu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqStrict(reqStrict),
    .inMis    (inMis),
    .spanQ    (spanQ),
    .busAck   (busAck),
    .reqReady (reqReady),
    .busReq   (busReq),
    .rspDone  (rspDone),
    .rspExc   (rspExc),
    .ctl      (ctl)
  );

  lsu_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqSigned(reqSigned),
    .busData  (busData),
    .inMis    (inMis),
    .spanQ    (spanQ),
    .busAddr  (busAddr),
    .rspData  (rspData),
    .rspAddr  (rspAddr)
  );

  assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr)));

  assert_bus_aligned_R8: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busAddr[OFFW-1:0] == '0));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  assert_exc_no_bus_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspExc |-> (!busReq && !rspDone && !$past(busReq)));
endmodule

// File: tb/sim_load_split_unit.sv
`timescale 1ns/1ps
module sim_load_split_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqStrict = 1'b0;
  logic        reqSigned = 1'b0;
  logic        rspDone, rspExc;
  logic [31:0] rspData, rspAddr;
  logic        busReq;
  logic [31:0] busAddr;
  logic        busAck = 1'b0;
  logic [31:0] busData = '0;

  always #10 clk = ~clk;  // 50 MHz

  load_split_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqStrict(reqStrict), .reqSigned(reqSigned),
    .rspDone(rspDone), .rspExc(rspExc), .rspData(rspData), .rspAddr(rspAddr),
    .busReq(busReq), .busAddr(busAddr), .busAck(busAck), .busData(busData)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastAck = 0;
  int busLat = 0;
  int waitCnt = 0;
  int readCnt = 0;
  logic [31:0] rdAddr [4];

  function automatic logic [7:0] byteAt(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd37 + 32'd11;
    return t[7:0];
  endfunction

  function automatic logic [31:0] wordAt(input logic [31:0] a);
    return {byteAt(a + 3), byteAt(a + 2), byteAt(a + 1), byteAt(a)};
  endfunction

  function automatic logic [31:0] expData(input logic [31:0] a, input logic [1:0] sz, input logic sg);
    logic [31:0] v;
    int n;
    n = 1 << sz;
    v = '0;
    for (int i = 0; i < n; i++) v = v | (32'(byteAt(a + 32'(i))) << (8 * i));
    if (sg && n < 4 && v[8*n-1]) v = v | ~((32'd1 << (8 * n)) - 32'd1);
    return v;
  endfunction

  // bus memory model: ack after busLat extra cycles
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      busAck  <= 1'b0;
      waitCnt <= 0;
    end else begin
      busAck <= 1'b0;
      if (busReq && !busAck) begin
        if (waitCnt >= busLat) begin
          busAck  <= 1'b1;
          busData <= wordAt(busAddr);
          waitCnt <= 0;
          rdAddr[readCnt % 4] <= busAddr;
          readCnt <= readCnt + 1;
          lastAck <= cyc;
        end else begin
          waitCnt <= waitCnt + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runLoad(input logic [31:0] a, input logic [1:0] sz, input logic st, input logic sg,
                         input int lat, input logic expExc, input int expReads, input string tag);
    int base;
    int waited;
    logic earlyReady;
    logic [31:0] wbase;
    wbase = a & 32'hFFFF_FFFC;
    @(negedge clk);
    busLat = lat;
    base = readCnt;
    reqAddr = a; reqSize = sz; reqStrict = st; reqSigned = sg; reqValid = 1'b1;
    chk("R7", "ready before request", 32'(reqReady), 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    waited = 0;
    earlyReady = 1'b0;
    while (!(rspDone || rspExc) && waited < 60) begin
      if (reqReady) earlyReady = 1'b1;
      @(negedge clk);
      waited++;
    end
    if (reqReady) earlyReady = 1'b1;
    chk("R7", "ready low while busy", 32'(earlyReady), 32'd0);
    chk(tag, "exception flag", 32'(rspExc), 32'(expExc));
    chk(tag, "done flag", 32'(rspDone), 32'(!expExc));
    if (expExc) begin
      chk("R5", "fault address", rspAddr, a);
    end else begin
      chk(tag, "data", rspData, expData(a, sz, 1'b0) | (sg ? expData(a, sz, 1'b1) : 32'd0));
      if (sg) chk("R6", "signed data", rspData, expData(a, sz, 1'b1));
      else    chk("R6", "zero ext", rspData, expData(a, sz, 1'b0));
      chk("R8", "done after last ack", 32'(cyc - lastAck), 32'd2);
    end
    chk(tag, "bus read count", 32'(readCnt - base), 32'(expReads));
    if (expReads >= 1) chk(tag, "first read addr", rdAddr[base % 4], wbase);
    if (expReads >= 2) chk(tag, "second read addr", rdAddr[(base + 1) % 4], wbase + 32'd4);
    @(negedge clk);
    chk("R8", "single-cycle response", 32'({rspDone, rspExc}), 32'd0);
    chk("R7", "ready after response", 32'(reqReady), 32'd1);
  endtask

  // vector: [31:16] addr, [15:14] size, [13] strict, [12] signed, [11] exc, [9:8] reads
  localparam int NV = 16;
  localparam logic [31:0] VEC [NV] = '{
    {16'h1000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h00},  // R1
    {16'h100D, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00},  // R2
    {16'h100E, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00},  // R2
    {16'h100F, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00},  // R2
    {16'h1000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h00},  // R3
    {16'h1001, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h00},  // R3
    {16'h1002, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h00},  // R3
    {16'h1003, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00},  // R3
    {16'h1007, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h00},  // R4
    {16'h1005, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 8'h00},  // R6 negative byte
    {16'h1000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 8'h00},  // R6 positive byte
    {16'h1003, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 8'h00},  // R6 split halfword
    {16'h100D, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00},  // R5 word
    {16'h1001, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00},  // R5 odd halfword in one word
    {16'h1004, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 8'h00},  // R5 strict aligned
    {16'h10FF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 8'h00}   // R5 strict byte
  };

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    string tag;
    // R9: state held in reset
    repeat (3) @(negedge clk);
    chk("R9", "ready in reset", 32'(reqReady), 32'd1);
    chk("R9", "outputs idle in reset", 32'({busReq, rspDone, rspExc}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", "ready after reset", 32'(reqReady), 32'd1);
    chk("R9", "outputs idle after reset", 32'({busReq, rspDone, rspExc}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (v[13] && v[11])      tag = "R5";
      else if (v[12])          tag = "R6";
      else if (v[13])          tag = "R5";
      else if (v[15:14] == 2)  tag = (v[9:8] == 2) ? "R2" : "R1";
      else if (v[15:14] == 1)  tag = "R3";
      else                     tag = "R4";
      runLoad({16'h0000, v[31:16]}, v[15:14], v[13], v[12], i % 3, v[11], int'(v[9:8]), tag);
    end

    // R4: byte at every lane of one word
    for (int k = 0; k < 4; k++)
      runLoad(32'h0000_2040 + 32'(k), 2'd0, 1'b0, 1'b0, 0, 1'b0, 1, "R4");

    // R9: reset in the middle of a slow read
    @(negedge clk);
    busLat = 8;
    reqAddr = 32'h0000_3001; reqSize = 2'd2; reqStrict = 1'b0; reqSigned = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R8", "read held while waiting", 32'(busReq), 32'd1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R9", "read dropped by reset", 32'(busReq), 32'd0);
    chk("R9", "ready during reset", 32'(reqReady), 32'd1);
    rstN = 1'b1;
    runLoad(32'h0000_3002, 2'd2, 1'b0, 1'b1, 2, 1'b0, 2, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule